// File: doc/BRIEF.md
# Lock-Stepped Two-Direction Crossing Light Controller

This block runs the lamps of a four-way crossing with one three-colour light for the North-South road and one for the East-West road. Each light is a small state machine. It steps through green, yellow and red, in that order, and it moves only on a one-cycle transfer pulse. A central phase timer produces both transfer pulses.

The timer counts the green and yellow dwell of whichever light is not red. The green-to-yellow step of the running light is pulsed on its own. When the running light's yellow dwell ends, both lights are pulsed in the same cycle. The running light goes to red and the waiting light goes to green. The design therefore never has an all-red interval.

A concurrent checker inside the block watches both lights every cycle. It latches a sticky error flag if any of these goes wrong: the one-hot lamp rule, the pulse-only movement rule, or the cross-direction rules. Only reset clears the flag.

Top module: `xing_ctrl`

## Requirements
- R1: During and right after reset, `ns_lamp` shows green, `ew_lamp` shows red, both transfer outputs are low and `err` is low. The phase timer restarts from zero.
- R2: Each lamp vector is one-hot, with bit 2 = green, bit 1 = yellow and bit 0 = red (green 3'b100, yellow 3'b010, red 3'b001).
- R3: Each light cycles strictly green, then yellow, then red, then back to green.
- R4: A light whose transfer output is high in a cycle shows its next colour in the following cycle. A light whose transfer output is low holds its colour.
- R5: The running light stays green for exactly `GREEN_T` cycles.
- R6: The running light stays yellow for exactly `YELLOW_T` cycles.
- R7: In every cycle at least one light is red, so the two lights are never both green-or-yellow.
- R8: The two lights are never both red in the same cycle.
- R9: North-South yellow-to-red is pulsed in the same cycle as East-West red-to-green.
- R10: East-West yellow-to-red is pulsed in the same cycle as North-South red-to-green.
- R11: A green-to-yellow pulse on either light comes with no pulse on the other light.
- R12: In correct operation `err` stays low. It is sticky and is cleared only by reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ns_lamp | output | 3 | North-South lamps {green, yellow, red} |
| ew_lamp | output | 3 | East-West lamps {green, yellow, red} |
| ns_xfer | output | 1 | North-South transfer pulse |
| ew_xfer | output | 1 | East-West transfer pulse |
| err | output | 1 | Sticky invariant-violation flag |

## Verification
The bench compares both lights and both pulses, every cycle, against a period model of 2·(GREEN_T+YELLOW_T) cycles. It does this for the default timing and for a short instance with a one-cycle yellow, where the timer limit is zero. Several design faults would show up as a mismatch against that model:
- A controller that pulsed the two lights one cycle apart would open a both-red or both-running cycle.
- An off-by-one timer would stretch or shorten a dwell.
- A green-to-yellow step that also pulsed the waiting light would throw it out of order.

A reset in mid-phase checks that the timer really restarts. A design that kept its old count would produce a short first green.

// File: rtl/xing_ctrl.sv
module xing_ctrl #(
  parameter int GREEN_T  = 8,
  parameter int YELLOW_T = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic [2:0] ns_lamp,
  output logic [2:0] ew_lamp,
  output logic       ns_xfer,
  output logic       ew_xfer,
  output logic       err
);
  localparam int MAXT = (GREEN_T > YELLOW_T) ? GREEN_T : YELLOW_T;
  localparam int CW   = (MAXT < 2) ? 1 : $clog2(MAXT);
  localparam logic [CW-1:0] G_LIM = CW'(GREEN_T - 1);
  localparam logic [CW-1:0] Y_LIM = CW'(YELLOW_T - 1);

  typedef enum logic [1:0] {L_GRN = 2'd0, L_YEL = 2'd1, L_RED = 2'd2} lite_t;

  lite_t ns_st, ew_st, ns_prev, ew_prev;
  logic [CW-1:0] tmr;
  logic ns_run, act_grn, expire;
  logic ns_xfer_d, ew_xfer_d, bad;

  function automatic lite_t step(input lite_t s);
    case (s)
      L_GRN:   step = L_YEL;
      L_YEL:   step = L_RED;
      default: step = L_GRN;
    endcase
  endfunction

  function automatic logic [2:0] lamps(input lite_t s);
    case (s)
      L_GRN:   lamps = 3'b100;
      L_YEL:   lamps = 3'b010;
      L_RED:   lamps = 3'b001;
      default: lamps = 3'b000;
    endcase
  endfunction

  assign ns_run  = (ns_st != L_RED);
  assign act_grn = ns_run ? (ns_st == L_GRN) : (ew_st == L_GRN);
  assign expire  = (tmr == (act_grn ? G_LIM : Y_LIM));

  assign ns_xfer = expire && (ns_run  || ew_st == L_YEL);
  assign ew_xfer = expire && (!ns_run || ns_st == L_YEL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr   <= '0;
      ns_st <= L_GRN;
      ew_st <= L_RED;
    end else begin
      tmr <= expire ? '0 : tmr + 1'b1;
      if (ns_xfer) ns_st <= step(ns_st);
      if (ew_xfer) ew_st <= step(ew_st);
    end
  end

  assign ns_lamp = lamps(ns_st);
  assign ew_lamp = lamps(ew_st);

  always_comb begin
    bad = 1'b0;
    if ($countones(ns_lamp) != 1 || $countones(ew_lamp) != 1) bad = 1'b1;
    if (ns_st != ns_prev && !ns_xfer_d) bad = 1'b1;
    if (ew_st != ew_prev && !ew_xfer_d) bad = 1'b1;
    if (ns_st != L_RED && ew_st != L_RED) bad = 1'b1;
    if (ns_st == L_RED && ew_st == L_RED) bad = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ns_prev   <= L_GRN;
      ew_prev   <= L_RED;
      ns_xfer_d <= 1'b0;
      ew_xfer_d <= 1'b0;
      err       <= 1'b0;
    end else begin
      ns_prev   <= ns_st;
      ew_prev   <= ew_st;
      ns_xfer_d <= ns_xfer;
      ew_xfer_d <= ew_xfer;
      err       <= err | bad;
    end
  end
endmodule

module xing_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] ns_lamp,
  input logic [2:0] ew_lamp,
  input logic       ns_xfer,
  input logic       ew_xfer,
  input logic       err
);
  a_r2_ns_onehot: assert property (@(posedge clk) disable iff (!rst_n) $countones(ns_lamp) == 1);
  a_r2_ew_onehot: assert property (@(posedge clk) disable iff (!rst_n) $countones(ew_lamp) == 1);
  a_r4_ns_hold:   assert property (@(posedge clk) disable iff (!rst_n) !ns_xfer |=> $stable(ns_lamp));
  a_r4_ew_hold:   assert property (@(posedge clk) disable iff (!rst_n) !ew_xfer |=> $stable(ew_lamp));
  a_r3_ns_order:  assert property (@(posedge clk) disable iff (!rst_n)
                    ns_xfer && ns_lamp == 3'b100 |=> ns_lamp == 3'b010);
  a_r3_ew_order:  assert property (@(posedge clk) disable iff (!rst_n)
                    ew_xfer && ew_lamp == 3'b010 |=> ew_lamp == 3'b001);
  a_r7_one_red:   assert property (@(posedge clk) disable iff (!rst_n) ns_lamp[0] || ew_lamp[0]);
  a_r8_not_both_red: assert property (@(posedge clk) disable iff (!rst_n) !(ns_lamp[0] && ew_lamp[0]));
  a_r9_ns_y2r_pair:  assert property (@(posedge clk) disable iff (!rst_n)
                       ns_xfer && ns_lamp == 3'b010 |-> ew_xfer);
  a_r10_ew_y2r_pair: assert property (@(posedge clk) disable iff (!rst_n)
                       ew_xfer && ew_lamp == 3'b010 |-> ns_xfer);
  a_r11_green_alone: assert property (@(posedge clk) disable iff (!rst_n)
                       (ns_xfer && ns_lamp == 3'b100) || (ew_xfer && ew_lamp == 3'b100) |-> !(ns_xfer && ew_xfer));
  a_r12_no_err:      assert property (@(posedge clk) disable iff (!rst_n) !err);
endmodule

bind xing_ctrl xing_ctrl_chk u_chk (.*);

// File: tb/xing_ctrl_tb.sv
module xing_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [2:0] ns_a, ew_a, ns_b, ew_b;
  logic nx_a, ex_a, nx_b, ex_b, er_a, er_b;

  xing_ctrl #(.GREEN_T(8), .YELLOW_T(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .ns_lamp(ns_a), .ew_lamp(ew_a),
    .ns_xfer(nx_a), .ew_xfer(ex_a), .err(er_a));
  xing_ctrl #(.GREEN_T(2), .YELLOW_T(1)) u_fast (
    .clk(clk), .rst_n(rst_n), .ns_lamp(ns_b), .ew_lamp(ew_b),
    .ns_xfer(nx_b), .ew_xfer(ex_b), .err(er_b));

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [2:0] col(int c);
    return c == 0 ? 3'b100 : (c == 1 ? 3'b010 : 3'b001);
  endfunction

  function automatic string ctag(int c);
    return c == 0 ? "R5 green dwell" : (c == 1 ? "R6 yellow dwell" : "R3 red");
  endfunction

  // colour codes: 0 green, 1 yellow, 2 red
  task automatic model(int g, int y, int c, output int ns, output int ew,
                       output bit nx, output bit ex);
    int p = c % (2 * (g + y));
    ns = (p < g) ? 0 : (p < g + y) ? 1 : 2;
    ew = (p < g + y) ? 2 : (p < 2 * g + y) ? 0 : 1;
    nx = (p == g - 1) || (p == g + y - 1) || (p == 2 * (g + y) - 1);
    ex = (p == g + y - 1) || (p == 2 * g + y - 1) || (p == 2 * (g + y) - 1);
  endtask

  task automatic one_dut(int g, int y, int c, logic [2:0] nl, logic [2:0] el,
                         logic nx, logic ex, logic er, logic [2:0] nl_p,
                         logic [2:0] el_p, logic nx_p, logic ex_p);
    int mn, me; bit mnx, mex;
    model(g, y, c, mn, me, mnx, mex);
    chk($countones(nl) == 1 && $countones(el) == 1, "R2 one-hot", {nl, el}, {col(mn), col(me)});
    chk(nl == col(mn), {"NS ", ctag(mn)}, nl, col(mn));
    chk(el == col(me), {"EW ", ctag(me)}, el, col(me));
    chk(nl[0] || el[0], "R7 one red", {nl, el}, 0);
    chk(!(nl[0] && el[0]), "R8 not both red", {nl, el}, 0);
    if (mnx && mn == 1) chk(nx && ex, "R9 NS y->r with EW r->g", {nx, ex}, 3);
    else if (mex && me == 1) chk(nx && ex, "R10 EW y->r with NS r->g", {nx, ex}, 3);
    else if (mnx || mex) chk(nx == mnx && ex == mex, "R11 green step alone", {nx, ex}, {mnx, mex});
    else chk(!nx && !ex, "R4 no pulse", {nx, ex}, 0);
    if (c > 0) begin
      chk((nl != nl_p) == nx_p, "R4 NS moves only on pulse", nl, nl_p);
      chk((el != el_p) == ex_p, "R4 EW moves only on pulse", el, el_p);
      if (nl != nl_p) chk(nl == {nl_p[0], nl_p[2:1]}, "R3 NS order", nl, {nl_p[0], nl_p[2:1]});
      if (el != el_p) chk(el == {el_p[0], el_p[2:1]}, "R3 EW order", el, {el_p[0], el_p[2:1]});
    end
    chk(er == 1'b0, "R12 err low", er, 0);
  endtask

  task automatic run_cycles(int n);
    logic [2:0] pa_n = 0, pa_e = 0, pb_n = 0, pb_e = 0;
    logic pa_x = 0, pa_y = 0, pb_x = 0, pb_y = 0;
    for (int c = 0; c < n; c++) begin
      one_dut(8, 3, c, ns_a, ew_a, nx_a, ex_a, er_a, pa_n, pa_e, pa_x, pa_y);
      one_dut(2, 1, c, ns_b, ew_b, nx_b, ex_b, er_b, pb_n, pb_e, pb_x, pb_y);
      pa_n = ns_a; pa_e = ew_a; pa_x = nx_a; pa_y = ex_a;
      pb_n = ns_b; pb_e = ew_b; pb_x = nx_b; pb_y = ex_b;
      @(negedge clk);
    end
  endtask

  task automatic t_reset_state();
    chk(ns_a == 3'b100 && ns_b == 3'b100, "R1 NS green in reset", ns_a, 3'b100);
    chk(ew_a == 3'b001 && ew_b == 3'b001, "R1 EW red in reset", ew_a, 3'b001);
    chk(!nx_a && !ex_a && !nx_b && !ex_b, "R1 no pulses in reset", {nx_a, ex_a}, 0);
    chk(!er_a && !er_b, "R1 err low in reset", er_a, 0);
  endtask

  task automatic t_full_periods();
    run_cycles(3 * 22);
  endtask

  task automatic t_mid_reset();
    run_cycles(13);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    run_cycles(30);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    t_full_periods();
    t_mid_reset();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule